// File: doc/BRIEF.md
# Neighbor Word Exchange Unit

This unit lets a compute engine swap single words with up to four adjacent engines. It has two request ports. In any cycle each port may either send one word toward a chosen neighbor or take one word from a chosen neighbor. Every outgoing direction is a one-word mailbox held in this unit: a data register and a full flag. The neighbor on the far side sees the flag and the data, and signals when it has consumed the word.

The incoming direction works the other way round. Each neighbor presents its own mailbox word and full flag for this engine. The unit pulses a consume strobe back when a local read takes the word. Each port has its own stall output. It goes high when the requested read finds nothing waiting, or when a send would overwrite a word the neighbor has not yet consumed. The engine holds a stalled request and presents it again on the next cycle. A stalled request changes no state.

Neighbors are chosen by a 2-bit index. If both ports address the same direction of the same neighbor in one cycle, port 0 is served and port 1 stalls.

Top module: `nbr_xchg`

## Requirements
- R1: After reset every outgoing mailbox is empty (`tx_full` all zero).
- R2: A send to an empty outgoing mailbox succeeds without stall. On the next cycle `tx_full` for that neighbor is 1 and `tx_data` holds the sent word.
- R3: A send to a full outgoing mailbox whose neighbor does not consume in the same cycle stalls that port. The mailbox flag and data stay unchanged.
- R4: A send to a full outgoing mailbox in the same cycle as the neighbor's consume strobe succeeds. The new word is held and the flag stays 1.
- R5: A consume strobe from a neighbor clears that mailbox's flag on the next cycle when no send targets it. A strobe on an empty mailbox has no effect.
- R6: A read from a neighbor whose incoming flag is 1 does not stall. In the same cycle the word appears on the port's read data and `rx_take` pulses for that neighbor.
- R7: A read from a neighbor whose incoming flag is 0 stalls the port and raises no `rx_take` bit.
- R8: When both ports send to the same neighbor, or both read from the same neighbor, in one cycle, port 0 is served and port 1 stalls.
- R9: The select value n (0 to 3) addresses neighbor n. That is bit n of the per-neighbor flag vectors and bits n*W to n*W+W-1 of the per-neighbor data buses. Port p uses bits 2p+1:2p of `req_sel` and bits p*W to p*W+W-1 of the port data buses.
- R10: A port with `req_vld` low never stalls and causes no consume or mailbox change.
- R11: A send and a read to the same neighbor in one cycle, on different ports, do not conflict. Both are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 2 | Per-port request valid |
| req_wr | input | 2 | Per-port direction: 1 send, 0 read |
| req_sel | input | 4 | Per-port neighbor index, 2 bits each |
| req_wdata | input | 64 | Per-port word to send |
| rsp_rdata | output | 64 | Per-port word read, zero when no read is served |
| stall | output | 2 | Per-port stall |
| tx_data | output | 128 | Outgoing mailbox words, one per neighbor |
| tx_full | output | 4 | Outgoing mailbox full flags |
| tx_take | input | 4 | Neighbor consumed its outgoing word |
| rx_data | input | 128 | Incoming words offered by neighbors |
| rx_full | input | 4 | Incoming word available from each neighbor |
| rx_take | output | 4 | Incoming word consumed this cycle |

## Verification
The bound checker examines every cycle for several cases:
- a read of an empty neighbor without stall;
- a consume strobe toward an empty incoming mailbox;
- a full outgoing mailbox that changes while nobody consumed it;
- a mailbox that fails to fill after a served send, or fails to drain after a lone consume;
- an idle port that stalls;
- a same-link clash where port 1 is not stalled.

The word actually returned by a read, which of two contending senders' data lands in the mailbox, and a send and a consume coinciding on one link are shown only by the bench's directed and randomized scenarios against its mailbox model.

// File: rtl/nbr_xchg_pkg.sv
package nbr_xchg_pkg;
    localparam int unsigned NBR_SEL_W = 2;
    localparam int unsigned NBR_COUNT = 1 << NBR_SEL_W;
    localparam logic        DIR_WRITE = 1'b1;
    localparam logic        DIR_READ  = 1'b0;
endpackage

// File: rtl/nbr_xchg_arb.sv
module nbr_xchg_arb #(
    parameter int unsigned NP = 2,
    parameter int unsigned NN = 4,
    parameter int unsigned SW = 2,
    localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic [NP-1:0]    vld,
    input  logic [NP-1:0]    wr,
    input  logic [NP*SW-1:0] sel,
    input  logic [NN-1:0]    tx_full,
    input  logic [NN-1:0]    tx_take,
    input  logic [NN-1:0]    rx_full,
    output logic [NP-1:0]    stall,
    output logic [NP-1:0]    rd_ok,
    output logic [NN-1:0]    wr_en,
    output logic [NN*PW-1:0] wr_port,
    output logic [NN-1:0]    rd_take
);
    import nbr_xchg_pkg::*;

    // Lower port index is visited first, so it wins every same-link clash.
    always_comb begin
        logic [NN-1:0] wtaken;
        logic [NN-1:0] rtaken;
        int            n;
        wtaken  = '0;
        rtaken  = '0;
        stall   = '0;
        rd_ok   = '0;
        wr_port = '0;
        for (int p = 0; p < int'(NP); p++) begin
            n = int'(sel[p*SW +: SW]);
            if (vld[p]) begin
                if (wr[p] == DIR_WRITE) begin
                    if (wtaken[n] || (tx_full[n] && !tx_take[n])) begin
                        stall[p] = 1'b1;
                    end else begin
                        wtaken[n]           = 1'b1;
                        wr_port[n*PW +: PW] = PW'(p);
                    end
                end else begin
                    if (rtaken[n] || !rx_full[n]) begin
                        stall[p] = 1'b1;
                    end else begin
                        rtaken[n] = 1'b1;
                        rd_ok[p]  = 1'b1;
                    end
                end
            end
        end
        wr_en   = wtaken;
        rd_take = rtaken;
    end
endmodule

// File: rtl/nbr_xchg_link.sv
module nbr_xchg_link #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (wr_en) begin
            slot_d.full = 1'b1;
            slot_d.data = wr_data;
        end else if (take) begin
            slot_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign full = slot_q.full;
    assign data = slot_q.data;
endmodule

// File: rtl/nbr_xchg.sv
module nbr_xchg #(
    parameter int unsigned DW = 32,
    parameter int unsigned NP = 2,
    localparam int unsigned SW = nbr_xchg_pkg::NBR_SEL_W,
    localparam int unsigned NN = nbr_xchg_pkg::NBR_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NP-1:0]    req_vld,
    input  logic [NP-1:0]    req_wr,
    input  logic [NP*SW-1:0] req_sel,
    input  logic [NP*DW-1:0] req_wdata,
    output logic [NP*DW-1:0] rsp_rdata,
    output logic [NP-1:0]    stall,
    output logic [NN*DW-1:0] tx_data,
    output logic [NN-1:0]    tx_full,
    input  logic [NN-1:0]    tx_take,
    input  logic [NN*DW-1:0] rx_data,
    input  logic [NN-1:0]    rx_full,
    output logic [NN-1:0]    rx_take
);
    localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1;

    logic [NP-1:0]    rd_ok;
    logic [NN-1:0]    wr_en;
    logic [NN*PW-1:0] wr_port;

    nbr_xchg_arb #(.NP(NP), .NN(NN), .SW(SW)) u_arb (
        .vld     (req_vld),
        .wr      (req_wr),
        .sel     (req_sel),
        .tx_full (tx_full),
        .tx_take (tx_take),
        .rx_full (rx_full),
        .stall   (stall),
        .rd_ok   (rd_ok),
        .wr_en   (wr_en),
        .wr_port (wr_port),
        .rd_take (rx_take)
    );

    for (genvar n = 0; n < int'(NN); n++) begin : g_link
        logic [DW-1:0] link_wdata;
        always_comb begin
            link_wdata = req_wdata[int'(wr_port[n*PW +: PW])*DW +: DW];
        end
        nbr_xchg_link #(.DW(DW)) u_link (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[n]),
            .wr_data (link_wdata),
            .take    (tx_take[n]),
            .full    (tx_full[n]),
            .data    (tx_data[n*DW +: DW])
        );
    end

    for (genvar p = 0; p < int'(NP); p++) begin : g_rd
        always_comb begin
            rsp_rdata[p*DW +: DW] = rd_ok[p] ? rx_data[int'(req_sel[p*SW +: SW])*DW +: DW] : '0;
        end
    end
endmodule

// File: rtl/nbr_xchg_chk.sv
module nbr_xchg_chk #(
    parameter int unsigned DW = 32,
    parameter int unsigned NP = 2,
    parameter int unsigned SW = 2,
    parameter int unsigned NN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NP-1:0]    req_vld,
    input logic [NP-1:0]    req_wr,
    input logic [NP*SW-1:0] req_sel,
    input logic [NP-1:0]    stall,
    input logic [NN*DW-1:0] tx_data,
    input logic [NN-1:0]    tx_full,
    input logic [NN-1:0]    tx_take,
    input logic [NN-1:0]    rx_full,
    input logic [NN-1:0]    rx_take
);
    logic [NN-1:0] served_wr;

    always_comb begin
        served_wr = '0;
        for (int p = 0; p < int'(NP); p++) begin
            if (req_vld[p] && req_wr[p] && !stall[p]) begin
                served_wr[int'(req_sel[p*SW +: SW])] = 1'b1;
            end
        end
    end

    for (genvar p = 0; p < int'(NP); p++) begin : g_port
        assert_rd_empty_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (req_vld[p] && !req_wr[p] && !rx_full[req_sel[p*SW +: SW]]) |-> stall[p]);
        assert_idle_no_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !req_vld[p] |-> !stall[p]);
    end

    for (genvar n = 0; n < int'(NN); n++) begin : g_nbr
        assert_take_needs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rx_take[n] |-> rx_full[n]);
        assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_full[n] && !tx_take[n]) |=> tx_full[n]);
        assert_data_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_full[n] && !tx_take[n]) |=> $stable(tx_data[n*DW +: DW]));
        assert_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_take[n] && !served_wr[n]) |=> !tx_full[n]);
        assert_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
            served_wr[n] |=> tx_full[n]);
    end

    if (NP >= 2) begin : g_clash
        assert_clash_port1_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (req_vld[0] && req_vld[1] && (req_wr[0] == req_wr[1])
             && (req_sel[SW-1:0] == req_sel[2*SW-1:SW])) |-> stall[1]);
    end
endmodule

bind nbr_xchg nbr_xchg_chk #(.DW(DW), .NP(NP), .SW(SW), .NN(NN)) u_chk (.*);

// File: tb/nbr_xchg_tb.sv
module nbr_xchg_tb;
    localparam int DW = 32;
    localparam int NP = 2;
    localparam int SW = 2;
    localparam int NN = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    req_vld = '0;
    logic [NP-1:0]    req_wr = '0;
    logic [NP*SW-1:0] req_sel = '0;
    logic [NP*DW-1:0] req_wdata = '0;
    logic [NP*DW-1:0] rsp_rdata;
    logic [NP-1:0]    stall;
    logic [NN*DW-1:0] tx_data;
    logic [NN-1:0]    tx_full;
    logic [NN-1:0]    tx_take = '0;
    logic [NN*DW-1:0] rx_data = '0;
    logic [NN-1:0]    rx_full = '0;
    logic [NN-1:0]    rx_take;

    int checks = 0;
    int fails  = 0;
    logic          mfull [NN];
    logic [DW-1:0] mdata [NN];

    always #5 clk = ~clk;

    nbr_xchg #(.DW(DW), .NP(NP)) u_dut (.*);

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_req(input int p, input logic v, input logic w, input int s, input logic [DW-1:0] d);
        req_vld[p] = v;
        req_wr[p]  = w;
        req_sel[p*SW +: SW] = SW'(s);
        req_wdata[p*DW +: DW] = d;
    endtask

    // Checks outputs of the current cycle against the model, then advances the model.
    task automatic step();
        logic [NN-1:0] wused;
        logic [NN-1:0] rused;
        logic [DW-1:0] ndata [NN];
        logic          es;
        string         tag;
        int            n;
        #1;
        for (int k = 0; k < NN; k++) begin
            check("R5 tx_full", DW'(tx_full[k]), DW'(mfull[k]));
            if (mfull[k]) check("R2 tx_data", tx_data[k*DW +: DW], mdata[k]);
            ndata[k] = mdata[k];
        end
        wused = '0;
        rused = '0;
        for (int p = 0; p < NP; p++) begin
            n  = int'(req_sel[p*SW +: SW]);
            es = 1'b0;
            tag = "R10 stall";
            if (req_vld[p] && req_wr[p]) begin
                if (wused[n]) begin es = 1'b1; tag = "R8 stall"; end
                else if (mfull[n] && !tx_take[n]) begin es = 1'b1; tag = "R3 stall"; end
                else begin
                    tag = mfull[n] ? "R4 stall" : "R2 stall";
                    wused[n] = 1'b1;
                    ndata[n] = req_wdata[p*DW +: DW];
                end
            end else if (req_vld[p]) begin
                if (rused[n]) begin es = 1'b1; tag = "R8 stall"; end
                else if (!rx_full[n]) begin es = 1'b1; tag = "R7 stall"; end
                else begin
                    tag = "R6 stall";
                    rused[n] = 1'b1;
                    check("R9 rdata", rsp_rdata[p*DW +: DW], rx_data[n*DW +: DW]);
                end
            end
            check(tag, DW'(stall[p]), DW'(es));
        end
        check("R6 rx_take", DW'(rx_take), DW'(rused));
        for (int k = 0; k < NN; k++) begin
            if (wused[k]) begin mfull[k] = 1'b1; mdata[k] = ndata[k]; end
            else if (tx_take[k]) mfull[k] = 1'b0;
        end
    endtask

    task automatic idle();
        req_vld = '0; tx_take = '0; rx_full = '0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < NN; k++) begin mfull[k] = 1'b0; mdata[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 tx_full", DW'(tx_full), '0);
        check("R1 stall", DW'(stall), '0);

        // R2: send to empty mailbox 2
        @(negedge clk); idle(); set_req(0, 1, 1, 2, 32'hA5A5_0001); step();
        // R3: send again without consume
        @(negedge clk); set_req(0, 1, 1, 2, 32'hA5A5_0002); step();
        // R4: send together with consume
        @(negedge clk); tx_take = 4'b0100; step();
        // R8: both ports send to neighbor 1
        @(negedge clk); idle(); set_req(0, 1, 1, 1, 32'h1111_0000); set_req(1, 1, 1, 1, 32'h2222_0000); step();
        // R11: send and read same neighbor on different ports
        @(negedge clk); idle(); rx_full = 4'b1000; rx_data[3*DW +: DW] = 32'hCAFE_0003;
        set_req(0, 1, 1, 3, 32'h3333_0000); set_req(1, 1, 0, 3, '0); step();
        // R8: both ports read neighbor 3
        @(negedge clk); set_req(0, 1, 0, 3, '0); step();
        // R7 / R10: read empty neighbor, other port idle
        @(negedge clk); idle(); set_req(0, 1, 0, 0, '0); step();
        // R5: consume all, no sends
        @(negedge clk); idle(); tx_take = '1; step();
        // R5: consume on empty mailboxes is ignored
        @(negedge clk); tx_take = '1; step();

        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++)
                set_req(p, ($urandom % 4) != 0, $urandom % 2, $urandom % NN, $urandom);
            tx_take = NN'($urandom);
            rx_full = NN'($urandom);
            for (int k = 0; k < NN; k++) rx_data[k*DW +: DW] = $urandom;
            step();
        end

        @(negedge clk); idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule